// File: doc/BRIEF.md
# Transaction-Boundary Debug Supporter for a Bus-Master Core

This block sits next to one bus-master core and watches its request handshake and its response completions. It keeps a saturating count of issued transactions and a free-running timer, and it can log a debug event without disturbing the core. The log holds the transaction count, the timer value and a fixed identifier of this core.

When the external debugger asks for a stop, the block does not freeze the core in mid-flight. It first raises a block signal so that the master starts nothing new. It then waits until every outstanding transaction has completed, and only then gates the core clock through a glitch-free latch gate. While the core is held, a step request reopens the block signal for exactly one new transaction and then drains and halts again. Dropping the stop request resumes normal running. A clock multiplexer lets the debugger drive the core from a separate debug clock, for example for scan dumps. A small registered read port exposes the live and captured values.

Top module: `master_txn_debug`

## Requirements
- R1: After a synchronous reset, `txn_block`, `txn_done`, `core_stopped` and `evt_flag` are low, and every information register reads zero, except the live timer at address 1.
- R2: The transaction count at address 0 increases by one for each cycle in which `req_valid` and `req_ready` are both high. It holds when `req_valid` is high and `req_ready` is low, and it saturates at all ones.
- R3: The live timer at address 1 counts clock cycles from zero after reset. On each accepted request, address 2 takes the new count value and address 3 takes the timer value of the acceptance cycle. A read returns, one cycle after `rd_addr` is sampled, the value from the cycle in which it was sampled. Values are zero-extended into `rd_data`.
- R4: With `dbg_en` high, the first cycle in which `evt_in` is high stores the current count at address 4 and the current timer at address 5. It also sets bit ID_W of address 6, with CORE_ID in bits ID_W-1:0, and raises `evt_flag` on the next cycle. Later events, and events while `dbg_en` is low, change none of these, and an event never raises `txn_block`.
- R5: With `dbg_en` and `stop_req` high, `txn_block` rises on the next cycle. `txn_done` rises once no transaction is outstanding: one cycle after the cycle that retired the last outstanding response. The core clock enable drops at the same edge.
- R6: While halted, a one-cycle `step_req` lowers `txn_block` and `txn_done` on the next cycle. After exactly one acceptance, `txn_block` is high again on the following cycle, and `txn_done` returns once that transaction has completed.
- R7: When `stop_req` falls, `txn_block`, `txn_done` and `core_stopped` are low on the next cycle, and `core_clk` pulses again from the following clock high phase.
- R8: With `clk_sel` low, `core_clk` equals `clk` while the gate is open and stays low in every high phase after `core_stopped` rises. `core_stopped` rises one cycle after `txn_done`. With `clk_sel` high, `core_clk` follows `dbg_clk`.
- R9: While `dbg_en` is low, `stop_req` and `step_req` have no effect: `txn_block` stays low and requests keep being accepted and counted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running system clock |
| rst | input | 1 | Synchronous active-high reset |
| dbg_en | input | 1 | Enables event capture and stop control |
| stop_req | input | 1 | Debugger request to halt at a transaction boundary |
| step_req | input | 1 | One-cycle pulse admitting one transaction while halted |
| evt_in | input | 1 | Debug event from the core or a trigger unit |
| req_valid | input | 1 | Master request valid |
| req_ready | input | 1 | Fabric ready for the request |
| rsp_done | input | 1 | Pulse marking completion of one outstanding transaction |
| txn_block | output | 1 | Master must not start a transaction while high |
| txn_done | output | 1 | Stopped with no transaction outstanding |
| core_stopped | output | 1 | Core clock is held by the gate |
| evt_flag | output | 1 | An event has been captured |
| dbg_clk | input | 1 | Alternate clock for debug operations |
| clk_sel | input | 1 | Selects `dbg_clk` as the core clock |
| core_clk | output | 1 | Gated or multiplexed clock for the core |
| rd_addr | input | ADDR_W | Information register address (0 count, 1 timer, 2 last count, 3 last timer, 4 event count, 5 event timer, 6 event id and valid) |
| rd_data | output | DATA_W | Registered read data |

## Verification
The bench drives a stop while two transactions are still outstanding and checks that `txn_done` waits for the second completion. A design that halted on the request cycle would lose in-flight responses. It takes a single step and checks that the count moves by exactly one and that `txn_block` closes again right after the acceptance; a loose gate would let a burst through. It repeats an event after a first capture, and fires one with debug disabled, expecting the logged count and timer to stay put; an overwriting log would show the later values. It also issues past the counter's limit, expecting it to pin at all ones rather than wrap to zero.

// File: rtl/mtd_pkg.sv
package mtd_pkg;

  typedef enum logic [1:0] {
    ST_RUN   = 2'd0,
    ST_DRAIN = 2'd1,
    ST_HALT  = 2'd2,
    ST_STEP  = 2'd3
  } stop_state_t;

  localparam int unsigned RA_CUR_CNT  = 0;
  localparam int unsigned RA_CUR_TMR  = 1;
  localparam int unsigned RA_LAST_CNT = 2;
  localparam int unsigned RA_LAST_TMR = 3;
  localparam int unsigned RA_EVT_CNT  = 4;
  localparam int unsigned RA_EVT_TMR  = 5;
  localparam int unsigned RA_EVT_ID   = 6;

endpackage

// File: rtl/mtd_track.sv
module mtd_track #(
  parameter int          CNT_W   = 16,
  parameter int          TMR_W   = 24,
  parameter int          OST_W   = 4,
  parameter int          ID_W    = 4,
  parameter int unsigned CORE_ID = 0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             dbg_en,
  input  logic             evt_in,
  input  logic             req_valid,
  input  logic             req_ready,
  input  logic             rsp_done,
  output logic [CNT_W-1:0] cur_cnt,
  output logic [TMR_W-1:0] cur_tmr,
  output logic [CNT_W-1:0] last_cnt,
  output logic [TMR_W-1:0] last_tmr,
  output logic [CNT_W-1:0] evt_cnt,
  output logic [TMR_W-1:0] evt_tmr,
  output logic [ID_W-1:0]  evt_id,
  output logic             evt_vld,
  output logic             accept,
  output logic             ost_zero
);

  localparam logic [CNT_W-1:0] CNT_MAX = '1;
  localparam logic [OST_W-1:0] OST_MAX = '1;

  logic [OST_W-1:0] ost;
  logic [CNT_W-1:0] cnt_nxt;
  logic             retire;

  assign accept   = req_valid & req_ready;
  assign ost_zero = (ost == '0);
  assign retire   = rsp_done & ~ost_zero;
  assign cnt_nxt  = (cur_cnt == CNT_MAX) ? cur_cnt : cur_cnt + 1'b1;

  // transaction counter, timer and last-issued stamp
  always_ff @(posedge clk) begin
    if (rst) begin
      cur_cnt  <= '0;
      cur_tmr  <= '0;
      last_cnt <= '0;
      last_tmr <= '0;
    end else begin
      cur_tmr <= cur_tmr + 1'b1;
      if (accept) begin
        cur_cnt  <= cnt_nxt;
        last_cnt <= cnt_nxt;
        last_tmr <= cur_tmr;
      end
    end
  end

  // outstanding transaction tracker
  always_ff @(posedge clk) begin
    if (rst) begin
      ost <= '0;
    end else begin
      case ({accept, retire})
        2'b10:   if (ost != OST_MAX) ost <= ost + 1'b1;
        2'b01:   ost <= ost - 1'b1;
        default: ost <= ost;
      endcase
    end
  end

  // event detector and first-event capture
  always_ff @(posedge clk) begin
    if (rst) begin
      evt_vld <= 1'b0;
      evt_cnt <= '0;
      evt_tmr <= '0;
      evt_id  <= '0;
    end else if (dbg_en && evt_in && !evt_vld) begin
      evt_vld <= 1'b1;
      evt_cnt <= cur_cnt;
      evt_tmr <= cur_tmr;
      evt_id  <= ID_W'(CORE_ID);
    end
  end

  AST_CNT_PINNED: assert property (@(posedge clk) disable iff (rst)
    (cur_cnt == CNT_MAX) |=> (cur_cnt == CNT_MAX)); // R2

  AST_CNT_STILL: assert property (@(posedge clk) disable iff (rst)
    !accept |=> $stable(cur_cnt)); // R2

  AST_LAST_STAMP: assert property (@(posedge clk) disable iff (rst)
    accept |=> (last_tmr == $past(cur_tmr))); // R3

  AST_EVT_KEPT: assert property (@(posedge clk) disable iff (rst)
    evt_vld |=> (evt_vld && $stable(evt_cnt) && $stable(evt_tmr))); // R4

endmodule

// File: rtl/mtd_stopper.sv
module mtd_stopper
  import mtd_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic stop_eff,
  input  logic step_eff,
  input  logic accept,
  input  logic ost_zero,
  output logic blk_q,
  output logic clk_en_q,
  output logic done_q,
  output logic stopped_q
);

  stop_state_t st, nxt;

  always_comb begin
    nxt = st;
    if (!stop_eff) begin
      nxt = ST_RUN;
    end else begin
      unique case (st)
        ST_RUN:   nxt = ST_DRAIN;
        ST_DRAIN: nxt = (ost_zero && !accept) ? ST_HALT : ST_DRAIN;
        ST_HALT:  nxt = step_eff ? ST_STEP : ST_HALT;
        ST_STEP:  nxt = accept ? ST_DRAIN : ST_STEP;
        default:  nxt = ST_RUN;
      endcase
    end
  end

  // registered control outputs decoded from the next state
  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= ST_RUN;
      blk_q     <= 1'b0;
      clk_en_q  <= 1'b1;
      done_q    <= 1'b0;
      stopped_q <= 1'b0;
    end else begin
      st        <= nxt;
      blk_q     <= (nxt == ST_DRAIN) || (nxt == ST_HALT);
      clk_en_q  <= (nxt != ST_HALT);
      done_q    <= (nxt == ST_HALT);
      stopped_q <= (nxt == ST_HALT) && !clk_en_q;
    end
  end

  AST_DONE_DRAINED: assert property (@(posedge clk) disable iff (rst)
    done_q |-> ost_zero); // R5

  AST_SINGLE_STEP: assert property (@(posedge clk) disable iff (rst)
    (st == ST_STEP && accept && stop_eff) |=> blk_q); // R6

  AST_RESUME: assert property (@(posedge clk) disable iff (rst)
    $fell(stop_eff) |=> (!blk_q && clk_en_q && !done_q)); // R7

  AST_GATE_SHUT: assert property (@(posedge clk) disable iff (rst)
    stopped_q |-> !clk_en_q); // R8

endmodule

// File: rtl/mtd_clkgate.sv
module mtd_clkgate #(
  parameter bit HAS_CLK_MUX = 1'b1
) (
  input  logic clk,
  input  logic en,
  input  logic dbg_clk,
  input  logic sel,
  output logic core_clk
);

  logic en_lat;
  logic gclk;

  // enable passes only during the low phase
  always_latch begin
    if (!clk) en_lat = en;
  end

  assign gclk = clk & en_lat;

  generate
    if (HAS_CLK_MUX) begin : g_mux
      assign core_clk = sel ? dbg_clk : gclk;
    end else begin : g_nomux
      logic unused_in;
      assign unused_in = dbg_clk ^ sel;
      assign core_clk  = gclk;
    end
  endgenerate

endmodule

// File: rtl/mtd_infobank.sv
module mtd_infobank
  import mtd_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int TMR_W  = 24,
  parameter int ID_W   = 4,
  parameter int DATA_W = 32,
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] rd_addr,
  input  logic [CNT_W-1:0]  cur_cnt,
  input  logic [TMR_W-1:0]  cur_tmr,
  input  logic [CNT_W-1:0]  last_cnt,
  input  logic [TMR_W-1:0]  last_tmr,
  input  logic [CNT_W-1:0]  evt_cnt,
  input  logic [TMR_W-1:0]  evt_tmr,
  input  logic [ID_W-1:0]   evt_id,
  input  logic              evt_vld,
  output logic [DATA_W-1:0] rd_data
);

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data <= '0;
    end else begin
      case (rd_addr)
        ADDR_W'(RA_CUR_CNT):  rd_data <= DATA_W'(cur_cnt);
        ADDR_W'(RA_CUR_TMR):  rd_data <= DATA_W'(cur_tmr);
        ADDR_W'(RA_LAST_CNT): rd_data <= DATA_W'(last_cnt);
        ADDR_W'(RA_LAST_TMR): rd_data <= DATA_W'(last_tmr);
        ADDR_W'(RA_EVT_CNT):  rd_data <= DATA_W'(evt_cnt);
        ADDR_W'(RA_EVT_TMR):  rd_data <= DATA_W'(evt_tmr);
        ADDR_W'(RA_EVT_ID):   rd_data <= DATA_W'({evt_vld, evt_id});
        default:              rd_data <= '0;
      endcase
    end
  end

endmodule

// File: rtl/master_txn_debug.sv
module master_txn_debug #(
  parameter int          CNT_W       = 16,
  parameter int          TMR_W       = 24,
  parameter int          OST_W       = 4,
  parameter int          ID_W        = 4,
  parameter int unsigned CORE_ID     = 0,
  parameter int          DATA_W      = 32,
  parameter int          ADDR_W      = 3,
  parameter bit          HAS_CLK_MUX = 1'b1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              dbg_en,
  input  logic              stop_req,
  input  logic              step_req,
  input  logic              evt_in,
  input  logic              req_valid,
  input  logic              req_ready,
  input  logic              rsp_done,
  output logic              txn_block,
  output logic              txn_done,
  output logic              core_stopped,
  output logic              evt_flag,
  input  logic              dbg_clk,
  input  logic              clk_sel,
  output logic              core_clk,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data
);

  logic [CNT_W-1:0] cur_cnt, last_cnt, evt_cnt;
  logic [TMR_W-1:0] cur_tmr, last_tmr, evt_tmr;
  logic [ID_W-1:0]  evt_id;
  logic             evt_vld, accept, ost_zero, clk_en;
  logic             stop_eff, step_eff;

  assign stop_eff = stop_req & dbg_en;
  assign step_eff = step_req & dbg_en;
  assign evt_flag = evt_vld;

  mtd_track #(
    .CNT_W(CNT_W), .TMR_W(TMR_W), .OST_W(OST_W), .ID_W(ID_W), .CORE_ID(CORE_ID)
  ) u_track (
    .clk(clk), .rst(rst), .dbg_en(dbg_en), .evt_in(evt_in),
    .req_valid(req_valid), .req_ready(req_ready), .rsp_done(rsp_done),
    .cur_cnt(cur_cnt), .cur_tmr(cur_tmr), .last_cnt(last_cnt), .last_tmr(last_tmr),
    .evt_cnt(evt_cnt), .evt_tmr(evt_tmr), .evt_id(evt_id), .evt_vld(evt_vld),
    .accept(accept), .ost_zero(ost_zero)
  );

  mtd_stopper u_stop (
    .clk(clk), .rst(rst), .stop_eff(stop_eff), .step_eff(step_eff),
    .accept(accept), .ost_zero(ost_zero), .blk_q(txn_block),
    .clk_en_q(clk_en), .done_q(txn_done), .stopped_q(core_stopped)
  );

  mtd_clkgate #(.HAS_CLK_MUX(HAS_CLK_MUX)) u_cg (
    .clk(clk), .en(clk_en), .dbg_clk(dbg_clk), .sel(clk_sel), .core_clk(core_clk)
  );

  mtd_infobank #(
    .CNT_W(CNT_W), .TMR_W(TMR_W), .ID_W(ID_W), .DATA_W(DATA_W), .ADDR_W(ADDR_W)
  ) u_bank (
    .clk(clk), .rst(rst), .rd_addr(rd_addr),
    .cur_cnt(cur_cnt), .cur_tmr(cur_tmr), .last_cnt(last_cnt), .last_tmr(last_tmr),
    .evt_cnt(evt_cnt), .evt_tmr(evt_tmr), .evt_id(evt_id), .evt_vld(evt_vld),
    .rd_data(rd_data)
  );

endmodule

// File: tb/master_txn_debug_test.sv
`timescale 1ns/100ps
module master_txn_debug_test;

  localparam int CNT_W = 4, TMR_W = 16, OST_W = 4, ID_W = 4, CORE_ID = 5;
  localparam int DATA_W = 32, ADDR_W = 3;
  localparam int CNT_TOP = 15;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst, dbg_en, stop_req, step_req, evt_in, req_valid, req_ready, rsp_done;
  logic txn_block, txn_done, core_stopped, evt_flag, dbg_clk, clk_sel, core_clk;
  logic [ADDR_W-1:0] rd_addr;
  logic [DATA_W-1:0] rd_data;

  master_txn_debug #(
    .CNT_W(CNT_W), .TMR_W(TMR_W), .OST_W(OST_W), .ID_W(ID_W),
    .CORE_ID(CORE_ID), .DATA_W(DATA_W), .ADDR_W(ADDR_W)
  ) uut (
    .clk(clk), .rst(rst), .dbg_en(dbg_en), .stop_req(stop_req), .step_req(step_req),
    .evt_in(evt_in), .req_valid(req_valid), .req_ready(req_ready), .rsp_done(rsp_done),
    .txn_block(txn_block), .txn_done(txn_done), .core_stopped(core_stopped),
    .evt_flag(evt_flag), .dbg_clk(dbg_clk), .clk_sel(clk_sel), .core_clk(core_clk),
    .rd_addr(rd_addr), .rd_data(rd_data)
  );

  int checks = 0, fails = 0;
  int tcnt;
  int exp_cnt = 0, last_t = 0, evc = 0, evt = 0;
  bit finished = 0;

  always @(posedge clk) if (rst) tcnt <= 0; else tcnt <= tcnt + 1;

  typedef struct {
    logic [DATA_W-1:0] e;
    string             r;
  } rd_item_t;
  rd_item_t sbq[$];

  task automatic chk(input string r, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", r, act, exp);
    end
  endtask

  // driver side of the read scoreboard
  task automatic rd_expect(input int a, input int e, input string r);
    rd_item_t it;
    @(negedge clk);
    rd_addr = ADDR_W'(a);
    it.e = DATA_W'(e);
    it.r = r;
    sbq.push_back(it);
  endtask

  task automatic rd_timer(input string r);
    rd_item_t it;
    @(negedge clk);
    rd_addr = ADDR_W'(1);
    it.e = DATA_W'(tcnt);
    it.r = r;
    sbq.push_back(it);
  endtask

  // monitor side: compare the registered read one edge later
  always @(posedge clk) begin
    if (sbq.size() > 0) begin
      rd_item_t it;
      it = sbq.pop_front();
      @(negedge clk);
      chk(it.r, 64'(rd_data), 64'(it.e));
    end
  end

  task automatic issue();
    @(negedge clk);
    req_valid = 1'b1;
    req_ready = 1'b1;
    last_t = tcnt;
    @(negedge clk);
    req_valid = 1'b0;
    if (exp_cnt < CNT_TOP) exp_cnt++;
  endtask

  task automatic respond();
    @(negedge clk);
    rsp_done = 1'b1;
    @(negedge clk);
    rsp_done = 1'b0;
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog actual=timeout expected=completion");
    summary();
  end

  initial begin
    rst = 1; dbg_en = 0; stop_req = 0; step_req = 0; evt_in = 0;
    req_valid = 0; req_ready = 1; rsp_done = 0; dbg_clk = 0; clk_sel = 0; rd_addr = '0;
    repeat (3) @(negedge clk);
    rst = 0;
    chk("R1 block", 64'(txn_block), 0);
    chk("R1 done", 64'(txn_done), 0);
    chk("R1 stopped", 64'(core_stopped), 0);
    chk("R1 evt_flag", 64'(evt_flag), 0);
    rd_expect(0, 0, "R1 count");
    rd_expect(2, 0, "R1 last count");
    rd_expect(3, 0, "R1 last timer");
    rd_expect(4, 0, "R1 event count");
    rd_expect(5, 0, "R1 event timer");
    rd_expect(6, 0, "R1 event id");
    rd_timer("R3 live timer");

    // R2 / R3 basic counting and stamping
    repeat (3) begin issue(); respond(); end
    rd_expect(0, exp_cnt, "R2 count after three");
    rd_expect(2, exp_cnt, "R3 last count");
    rd_expect(3, last_t, "R3 last timer");
    @(negedge clk); req_valid = 1; req_ready = 0;
    @(negedge clk); req_valid = 0; req_ready = 1;
    rd_expect(0, exp_cnt, "R2 no ready no count");

    // R4 events
    @(negedge clk); evt_in = 1;
    @(negedge clk); evt_in = 0;
    @(negedge clk);
    chk("R4 disabled event flag", 64'(evt_flag), 0);
    rd_expect(6, 0, "R4 disabled event id");
    @(negedge clk); dbg_en = 1; evt_in = 1; evc = exp_cnt; evt = tcnt;
    @(negedge clk); evt_in = 0;
    chk("R4 flag", 64'(evt_flag), 1);
    chk("R4 no block", 64'(txn_block), 0);
    issue(); respond();
    @(negedge clk); evt_in = 1;
    @(negedge clk); evt_in = 0;
    rd_expect(4, evc, "R4 event count");
    rd_expect(5, evt, "R4 event timer");
    rd_expect(6, (1 << ID_W) | CORE_ID, "R4 event id");

    // R9 stop ignored while disabled
    @(negedge clk); dbg_en = 0; stop_req = 1;
    repeat (2) @(negedge clk);
    chk("R9 block", 64'(txn_block), 0);
    issue(); respond();
    rd_expect(0, exp_cnt, "R9 count");
    @(negedge clk); stop_req = 0;
    @(negedge clk); dbg_en = 1;

    // R5 stop with two outstanding
    issue(); issue();
    @(negedge clk); stop_req = 1;
    @(negedge clk);
    chk("R5 block", 64'(txn_block), 1);
    chk("R5 done early", 64'(txn_done), 0);
    respond();
    chk("R5 done one left", 64'(txn_done), 0);
    respond();
    chk("R5 done same cycle", 64'(txn_done), 0);
    @(negedge clk);
    chk("R5 done", 64'(txn_done), 1);
    chk("R8 stopped lags", 64'(core_stopped), 0);
    @(negedge clk);
    chk("R8 stopped", 64'(core_stopped), 1);
    @(posedge clk); #1;
    chk("R8 clock held low", 64'(core_clk), 0);
    rd_expect(0, exp_cnt, "R5 count frozen");

    // R6 single step
    @(negedge clk); step_req = 1;
    @(negedge clk); step_req = 0;
    chk("R6 gate open", 64'(txn_block), 0);
    chk("R6 done low", 64'(txn_done), 0);
    issue();
    chk("R6 gate closed after one", 64'(txn_block), 1);
    repeat (2) @(negedge clk);
    chk("R6 waits completion", 64'(txn_done), 0);
    respond();
    @(negedge clk);
    chk("R6 done again", 64'(txn_done), 1);
    rd_expect(0, exp_cnt, "R6 one counted");

    // R7 resume
    @(negedge clk); stop_req = 0;
    @(negedge clk);
    chk("R7 block", 64'(txn_block), 0);
    chk("R7 done", 64'(txn_done), 0);
    chk("R7 stopped", 64'(core_stopped), 0);
    @(posedge clk); #1;
    chk("R7 clock running", 64'(core_clk), 1);
    issue(); respond();
    rd_expect(0, exp_cnt, "R7 counting resumed");

    // R8 clock multiplexer
    @(negedge clk); clk_sel = 1; dbg_clk = 1;
    #1 chk("R8 mux high", 64'(core_clk), 1);
    @(posedge clk); dbg_clk = 0;
    #1 chk("R8 mux low", 64'(core_clk), 0);
    @(negedge clk); clk_sel = 0;

    // R2 saturation
    repeat (10) begin issue(); respond(); end
    rd_expect(0, CNT_TOP, "R2 saturated");
    rd_expect(2, CNT_TOP, "R3 last count saturated");

    wait (sbq.size() == 0);
    repeat (3) @(negedge clk);
    summary();
  end

endmodule